// File: doc/BRIEF.md
# Dual Store Queue Burst Flusher

This block holds two small write-combining queues. Each queue has eight 32-bit longwords. The processor fills them with ordinary longword writes and can read back any word. A flush command sends one whole queue to external memory as a single 32-byte burst.

The external address of a flush is built in one of two ways:
- With address translation disabled, the address comes from the flush request address plus a small per-queue high-address value, which is programmed through a separate register port.
- With translation enabled, the caller supplies an address that has already been translated, and only masking is applied to it.

Access protection and the translation itself are done elsewhere.

While a burst is in progress, the queue being sent is frozen. A write to that queue is stalled until the last beat has been accepted. A write to the other queue completes without delay.

Top module: `sqf_top`

## Requirements
- R1: After reset, `busy`, `bm_valid` and `cpu_stall` are 0 and `flush_ready` is 1. All sixteen words and both high-address values read as zero.
- R2: A write stores `cpu_wdata` into word number `cpu_addr[5:2]`. `cpu_rdata` always shows the word selected by `cpu_addr[5:2]`, and all other address bits are ignored. Words 0..7 form queue 0 and words 8..15 form queue 1.
- R3: A flush request is accepted when `flush_req` is 1 and `flush_ready` is 1. Bit 5 of `flush_addr` chooses the queue that is sent.
- R4: With `flush_xlat` = 0, the burst address is `(flush_addr & 32'h03FF_FFE0) | (hi << 24)`. Here `hi` is the chosen queue's high-address value, sampled when the request is accepted.
- R5: With `flush_xlat` = 1, the burst address is `flush_addr & 32'h1FFF_FFE0`.
- R6: An accepted flush produces exactly eight beats, starting on the following cycle. The beats carry the chosen queue's words in ascending order. `bm_last` is 1 only on the eighth beat, and `bm_addr` stays constant and 32-byte aligned for the whole burst.
- R7: `busy` stays 1 from the cycle after acceptance until the cycle after the last beat is accepted. While `busy` is 1, `flush_ready` is 0 and any flush request is ignored.
- R8: While `busy` is 1, a write whose `cpu_addr[5]` names the queue being sent raises `cpu_stall` and does not take effect. It completes once `busy` falls. A write to the other queue completes at once.
- R9: A register-port write (`qctl_we`, with `qctl_sel` selecting the queue) keeps only `qctl_wdata[2:0]` as that queue's high-address value.
- R10: While `bm_ready` is 0, the current beat's `bm_data`, `bm_last` and `bm_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Access address; bits 5:2 pick the word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for `cpu_addr` |
| cpu_stall | output | 1 | Write held off by an active burst |
| qctl_we | input | 1 | High-address register write strobe |
| qctl_sel | input | 1 | High-address register index (queue) |
| qctl_wdata | input | 32 | High-address register write data, low 3 bits kept |
| flush_req | input | 1 | Flush command |
| flush_xlat | input | 1 | 1 = address already translated |
| flush_addr | input | 32 | Flush request address |
| flush_ready | output | 1 | Flush command can be accepted |
| busy | output | 1 | Burst in progress |
| bm_valid | output | 1 | Burst beat valid |
| bm_ready | input | 1 | Burst beat accepted by memory |
| bm_addr | output | 32 | Burst start address |
| bm_data | output | 32 | Burst beat data |
| bm_last | output | 1 | Final beat of the burst |

## Verification
The hardest situation to reach from the ports combines three events inside one burst under back-pressure: a write to the other queue, a stalled write to the queue being sent, and an ignored flush request. The stimulus arranges these on fixed cycles after acceptance, while `bm_ready` is drawn at random. The stalled write is held across the end of the burst so that the cycle it lands in can be checked. Afterwards, read-back and a second flush confirm that the burst content was frozen and that no extra burst followed the ignored request.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NQ       = 2;
    localparam int unsigned WPQ      = 8;
    localparam int unsigned HI_W     = 3;
    localparam int unsigned HI_SHIFT = 24;
    localparam int unsigned NWORDS   = NQ * WPQ;
    localparam int unsigned IDX_W    = $clog2(NWORDS);
    localparam int unsigned BEAT_W   = $clog2(WPQ);
    localparam int unsigned Q_W      = $clog2(NQ);
    localparam int unsigned QBIT_LO  = BEAT_W + 2;

    localparam logic [ADDR_W-1:0] RAW_MASK  = 32'h03FF_FFE0;
    localparam logic [ADDR_W-1:0] XLAT_MASK = 32'h1FFF_FFE0;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [Q_W-1:0] q;
        addr_t          addr;
    } burst_cmd_t;

    typedef enum logic {ST_IDLE, ST_SEND} burst_st_e;

    function automatic addr_t build_target(addr_t a, logic xlat, logic [HI_W-1:0] hi);
        if (xlat) return a & XLAT_MASK;
        return (a & RAW_MASK) | (addr_t'(hi) << HI_SHIFT);
    endfunction
endpackage

// File: rtl/sqf_store.sv
module sqf_store
    import sqf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     widx,
    input  word_t                wdata,
    input  logic [IDX_W-1:0]     ridx,
    output word_t                rdata,
    input  logic [Q_W-1:0]       bq,
    input  logic [BEAT_W-1:0]    bbeat,
    output word_t                bdata
);
    word_t mem [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
    assign bdata = mem[{bq, bbeat}];
endmodule

// File: rtl/sqf_target.sv
module sqf_target
    import sqf_pkg::*;
(
    input  addr_t            req_addr,
    input  logic             xlat,
    input  logic [HI_W-1:0]  hi_vals [NQ],
    output burst_cmd_t       cmd
);
    logic [Q_W-1:0] qsel;
    assign qsel     = req_addr[QBIT_LO +: Q_W];
    assign cmd.q    = qsel;
    assign cmd.addr = build_target(req_addr, xlat, hi_vals[qsel]);
endmodule

// File: rtl/sqf_burst_fsm.sv
module sqf_burst_fsm
    import sqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  burst_cmd_t        cmd_in,
    input  logic              beat_ready,
    output logic              active,
    output logic              last_beat,
    output logic [BEAT_W-1:0] beat,
    output burst_cmd_t        cmd_q
);
    burst_st_e st;
    logic      at_end;

    assign at_end    = (beat == BEAT_W'(WPQ - 1));
    assign active    = (st == ST_SEND);
    assign last_beat = active && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            beat  <= '0;
            cmd_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st    <= ST_SEND;
                    beat  <= '0;
                    cmd_q <= cmd_in;
                end
                ST_SEND: if (beat_ready) begin
                    if (at_end) begin
                        st   <= ST_IDLE;
                        beat <= '0;
                    end else begin
                        beat <= beat + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sqf_top.sv
module sqf_top
    import sqf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic [31:0] cpu_rdata,
    output logic        cpu_stall,
    input  logic        qctl_we,
    input  logic        qctl_sel,
    input  logic [31:0] qctl_wdata,
    input  logic        flush_req,
    input  logic        flush_xlat,
    input  logic [31:0] flush_addr,
    output logic        flush_ready,
    output logic        busy,
    output logic        bm_valid,
    input  logic        bm_ready,
    output logic [31:0] bm_addr,
    output logic [31:0] bm_data,
    output logic        bm_last
);
    logic [HI_W-1:0]   hi_q [NQ];
    burst_cmd_t        new_cmd, cur_cmd;
    logic [BEAT_W-1:0] beat;
    logic              active, last_beat, start, wr_fire;
    logic [Q_W-1:0]    wr_q;
    logic              unused_bits;

    assign unused_bits = ^{cpu_addr[31:IDX_W+2], cpu_addr[1:0], qctl_wdata[31:HI_W]};

    for (genvar g = 0; g < NQ; g++) begin : g_hi
        always_ff @(posedge clk) begin
            if (rst) hi_q[g] <= '0;
            else if (qctl_we && (Q_W'(qctl_sel) == Q_W'(g))) hi_q[g] <= qctl_wdata[HI_W-1:0];
        end
    end

    assign wr_q      = cpu_addr[QBIT_LO +: Q_W];
    assign cpu_stall = cpu_req && cpu_we && active && (wr_q == cur_cmd.q);
    assign wr_fire   = cpu_req && cpu_we && !cpu_stall;
    assign start     = flush_req && !active;

    sqf_target i_target (
        .req_addr (flush_addr),
        .xlat     (flush_xlat),
        .hi_vals  (hi_q),
        .cmd      (new_cmd)
    );

    sqf_burst_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd_in     (new_cmd),
        .beat_ready (bm_ready),
        .active     (active),
        .last_beat  (last_beat),
        .beat       (beat),
        .cmd_q      (cur_cmd)
    );

    sqf_store i_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_fire),
        .widx  (cpu_addr[IDX_W+1:2]),
        .wdata (cpu_wdata),
        .ridx  (cpu_addr[IDX_W+1:2]),
        .rdata (cpu_rdata),
        .bq    (cur_cmd.q),
        .bbeat (beat),
        .bdata (bm_data)
    );

    assign busy        = active;
    assign bm_valid    = active;
    assign flush_ready = !active;
    assign bm_addr     = cur_cmd.addr;
    assign bm_last     = last_beat;
endmodule

// File: rtl/sqf_checker.sv
module sqf_checker (
    input logic        clk,
    input logic        rst,
    input logic        cpu_we,
    input logic        cpu_stall,
    input logic        flush_req,
    input logic        flush_ready,
    input logic        busy,
    input logic        bm_valid,
    input logic        bm_ready,
    input logic [31:0] bm_addr,
    input logic [31:0] bm_data,
    input logic        bm_last
);
    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        flush_req && flush_ready |=> bm_valid && !bm_last);

    p_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        bm_valid |-> bm_addr[4:0] == 5'd0);

    p_addr_held_r6: assert property (@(posedge clk) disable iff (rst)
        bm_valid && !(bm_ready && bm_last) |=> bm_valid && $stable(bm_addr));

    p_done_r7: assert property (@(posedge clk) disable iff (rst)
        bm_valid && bm_ready && bm_last |=> !busy && flush_ready);

    p_stall_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> busy && cpu_we);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        bm_valid && !bm_ready |=> bm_valid && $stable(bm_data) && $stable(bm_last));
endmodule

bind sqf_top sqf_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_we      (cpu_we),
    .cpu_stall   (cpu_stall),
    .flush_req   (flush_req),
    .flush_ready (flush_ready),
    .busy        (busy),
    .bm_valid    (bm_valid),
    .bm_ready    (bm_ready),
    .bm_addr     (bm_addr),
    .bm_data     (bm_data),
    .bm_last     (bm_last)
);

// File: tb/test_sqf_top.sv
`timescale 1ns/1ps
module test_sqf_top;
    logic        clk = 0, rst = 1;
    logic        cpu_req = 0, cpu_we = 0;
    logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
    logic        cpu_stall;
    logic        qctl_we = 0, qctl_sel = 0;
    logic [31:0] qctl_wdata = 0;
    logic        flush_req = 0, flush_xlat = 0;
    logic [31:0] flush_addr = 0;
    logic        flush_ready, busy, bm_valid, bm_last;
    logic        bm_ready = 0;
    logic [31:0] bm_addr, bm_data;

    int checks = 0, failures = 0;
    logic [31:0] mem_m [16];
    logic [2:0]  hi_m [2];

    always #2 clk = ~clk;

    sqf_top i_sqf_top (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [31:0] exp_target(logic [31:0] a, logic x, logic [2:0] h);
        if (x) return a & 32'h1FFF_FFE0;
        return (a & 32'h03FF_FFE0) | ({29'd0, h} << 24);
    endfunction

    task automatic cpu_write(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_wdata = d;
        cpu_addr = {$urandom} & 32'hFFFF_FFC3 | {26'd0, idx, 2'b00};
        #1 chk(cpu_stall == 0, "R8 idle write not stalled", {31'd0, cpu_stall}, 0);
        mem_m[idx] = d;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic cpu_read(input logic [3:0] idx);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0;
        cpu_addr = {$urandom} & 32'hFFFF_FFC3 | {26'd0, idx, 2'b00};
        #1 chk(cpu_rdata === mem_m[idx], "R2 read word", cpu_rdata, mem_m[idx]);
        cpu_req = 0;
    endtask

    task automatic set_hi(input logic sel, input logic [31:0] v);
        @(negedge clk);
        qctl_we = 1; qctl_sel = sel; qctl_wdata = v;
        hi_m[sel] = v[2:0];
        @(negedge clk);
        qctl_we = 0;
    endtask

    task automatic do_flush(input logic [31:0] a, input logic x, input bit mode, input bit bp);
        logic [31:0] ta;
        logic        q;
        int          beat;
        logic [3:0]  pend_idx;
        logic [31:0] pend_dat;
        q  = a[5];
        @(negedge clk);
        flush_req = 1; flush_addr = a; flush_xlat = x;
        #1 chk(flush_ready == 1, "R3 ready before flush", {31'd0, flush_ready}, 1);
        ta = exp_target(a, x, hi_m[q]);
        @(negedge clk);
        flush_req = 0;
        beat = 0;
        pend_idx = {q, 3'd0}; pend_dat = 0;
        for (int cyc = 0; beat < 8 && cyc < 200; cyc++) begin
            bm_ready = bp ? 1'($urandom) : 1'b1;
            if (mode && cyc == 2) begin
                cpu_req = 1; cpu_we = 1;
                cpu_addr = {26'd0, ~q, 3'($urandom), 2'b00};
                cpu_wdata = $urandom;
            end
            if (mode && cyc == 3) begin
                pend_idx = {q, 3'($urandom)};
                pend_dat = $urandom;
                cpu_addr = {26'd0, pend_idx, 2'b00};
                cpu_wdata = pend_dat;
                flush_req = 1; flush_addr = ~a; flush_xlat = ~x;
            end
            if (mode && cyc == 4) flush_req = 0;
            #1;
            chk(bm_valid == 1, "R6 beat valid", {31'd0, bm_valid}, 1);
            chk(bm_addr === ta, x ? "R5 translated address" : "R4 raw address", bm_addr, ta);
            chk(bm_data === mem_m[{q, 3'(beat)}], "R6 beat data ascending", bm_data, mem_m[{q, 3'(beat)}]);
            chk(bm_last == (beat == 7), "R6 last flag", {31'd0, bm_last}, {31'd0, beat == 7});
            chk(busy == 1 && flush_ready == 0, "R7 busy during burst", {31'd0, busy}, 1);
            if (mode && cyc == 2) begin
                chk(cpu_stall == 0, "R8 other-queue write proceeds", {31'd0, cpu_stall}, 0);
                mem_m[cpu_addr[5:2]] = cpu_wdata;
            end
            if (mode && cyc >= 3)
                chk(cpu_stall == 1, "R8 same-queue write stalled", {31'd0, cpu_stall}, 1);
            if (bm_ready) beat++;
            @(negedge clk);
        end
        bm_ready = 0;
        #1;
        chk(busy == 0 && bm_valid == 0, "R7 busy clears after last beat", {31'd0, busy}, 0);
        if (mode) begin
            chk(cpu_stall == 0, "R8 stalled write released", {31'd0, cpu_stall}, 0);
            mem_m[pend_idx] = pend_dat;
        end
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
        #1 chk(bm_valid == 0, "R7 ignored flush gave no burst", {31'd0, bm_valid}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) mem_m[i] = 0;
        hi_m[0] = 0; hi_m[1] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(busy == 0 && bm_valid == 0 && cpu_stall == 0, "R1 reset idle", {30'd0, busy, bm_valid}, 0);
        chk(flush_ready == 1, "R1 reset ready", {31'd0, flush_ready}, 1);
        for (int i = 0; i < 16; i += 5) cpu_read(4'(i));
        do_flush(32'h0000_0020, 0, 0, 0);   // R1 zero hi and zero data

        for (int i = 0; i < 16; i++) cpu_write(4'(i), $urandom);
        for (int i = 0; i < 16; i++) cpu_read(4'(i));

        set_hi(0, 32'hFFFF_FFF5);            // R9 only low 3 bits kept
        set_hi(1, 32'h0000_00AA);
        do_flush(32'hABCD_E7C0, 0, 0, 0);    // R3 queue 0
        do_flush(32'h1234_5FE4, 0, 0, 1);    // R3 queue 1 with back-pressure R10
        do_flush(32'hF0F0_F0FF, 1, 0, 1);    // R5
        do_flush(32'h8765_4320, 1, 0, 0);

        for (int n = 0; n < 6; n++) begin
            set_hi(1'($urandom), $urandom);
            do_flush($urandom, 1'($urandom), n[0], 1);
        end
        do_flush(32'h0300_0000, 0, 1, 1);    // R8 interference on queue 0
        do_flush(32'h0000_0020, 1, 1, 1);    // R8 interference on queue 1
        for (int i = 0; i < 16; i++) cpu_read(4'(i));
        finish_up();
    end
endmodule